// File: doc/BRIEF.md
# Shift and video clock generator

This block runs in the dot-clock domain. From that clock it produces two slower clocks: a shift clock that drives video memory and a video clock that drives blanking and sync logic. It also produces the index of the input clock source, which an external multiplexer uses to pick the dot clock. The chosen source becomes the dot clock unchanged. The block itself only divides it down.

Both output clocks are taps of one free-running 8-bit counter, so their phase relationship is fixed. Writing an output-select value that disables both outputs holds the counter at zero. Releasing that value starts every device written the same way from the same phase. The same value is loaded by the power-on reset and by the synchronous hardware and software resets.

After reset, and after any write that changes the stored clock selection, a settle timer holds `clock_valid_o` low for a programmable number of dot-clock cycles.

Top module: `sv_clkgen_top`

## Requirements
- R1: While the asynchronous reset is active and on the first cycle after it: `src_sel_o` is 0, `sclk_o` and `vclk_o` are 0, and `clock_valid_o` is 0.
- R2: A write with `wr_addr_i`=0 stores `wr_data_i[3:0]` as the source code, and `src_sel_o` shows the decoded index from the cycle after the write edge. The decoding is: code 0 gives 0, code 1 gives 1, code 2 gives 2, code 3 or 4 gives 3 (single-ended), code 8 gives 4 (differential), and any other code gives 0. Bits 7:4 are ignored.
- R3: A write with `wr_addr_i`=1 stores `wr_data_i[5:0]`. Bits 7:6 are ignored. Bits [2:0] are the video code and bits [5:3] are the shift code. For a code n below 6, the output is the counter's bit n delayed by one register, which divides the dot clock by 2^(n+1). Codes 6 and 7 hold that output at 0.
- R4: The counter advances by one on every dot-clock edge and wraps from 255 to 0. With code n, each output stays high for 2^n cycles and low for 2^n cycles.
- R5: While output bits 5, 4, 2 and 1 are all 1, the counter is held at 0 and both outputs stay 0. On the first edge after that value is left, the counter is still 0. An output with code n then first goes high 2^n + 1 cycles after the write edge.
- R6: Both outputs come from the same counter. When the shift clock rises and the video code is lower than the shift code, the video clock falls on that same edge.
- R7: A one-cycle pulse on `hw_rst_i` or on `sw_rst_i` loads source code 0 and output value 0x36 (bits 5, 4, 2 and 1 set). This clears the counter and restarts the settle timer, the same as power-on reset.
- R8: After a reset edge or a write that changes a stored register value, `clock_valid_o` is 0 for exactly SETTLE_CYC cycles and then returns to 1. A write of the value already stored leaves `clock_valid_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| hw_rst_i | input | 1 | Hardware reset, synchronous, active high |
| sw_rst_i | input | 1 | Software reset, synchronous, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register select: 0 source select, 1 output select |
| wr_data_i | input | 8 | Write data |
| src_sel_o | output | 3 | Decoded input-source index |
| sclk_o | output | 1 | Shift clock |
| vclk_o | output | 1 | Video clock |
| clock_valid_o | output | 1 | High once the selection has settled |

## Verification
The hardest condition to reach from the ports is the exact counter phase on release of the synchronisation clear. An early or late count of one cycle changes only where the first edges fall. The stimulus parks the block in the clear pattern, then releases it with a shift code one step slower than the video code, and counts the cycles to the first rise of each output. A per-cycle reference model of the counter, the registers and the settle timer then follows a table of output codes. The table includes disabled codes and writes with the ignored bits set, and the model's values are compared with the ports on every cycle.

// File: rtl/sv_clkgen_pkg.sv
package sv_clkgen_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned NUM_TAPS = 2;
  localparam int unsigned TAP_VCLK = 0;
  localparam int unsigned TAP_SCLK = 1;
  localparam int unsigned OUT_W    = CODE_W * NUM_TAPS;
  localparam int unsigned SRC_W    = 3;
  localparam int unsigned NIB_W    = 4;

  localparam logic [OUT_W-1:0] OUT_RST = 6'b110110;

  function automatic logic [SRC_W-1:0] decode_src(input logic [NIB_W-1:0] nib);
    unique case (nib)
      4'd1:       return 3'd1;
      4'd2:       return 3'd2;
      4'd3, 4'd4: return 3'd3;
      4'd8:       return 3'd4;
      default:    return 3'd0;
    endcase
  endfunction

  function automatic logic code_off(input logic [CODE_W-1:0] code);
    return code[CODE_W-1] & code[CODE_W-2];
  endfunction
endpackage

// File: rtl/sv_clkgen_regs.sv
module sv_clkgen_regs
  import sv_clkgen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NIB_W-1:0]  in_sel_o,
  output logic [OUT_W-1:0]  out_sel_o,
  output logic              changed_o
);
  logic [NIB_W-1:0] in_q;
  logic [OUT_W-1:0] out_q;
  logic             wr_in, wr_out;

  assign wr_in  = wr_en_i & ~wr_addr_i;
  assign wr_out = wr_en_i &  wr_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      out_q <= OUT_RST;
    end else if (soft_rst_i) begin
      in_q  <= '0;
      out_q <= OUT_RST;
    end else begin
      if (wr_in)  in_q  <= wr_data_i[NIB_W-1:0];
      if (wr_out) out_q <= wr_data_i[OUT_W-1:0];
    end
  end

  assign changed_o = soft_rst_i
                   | (wr_in  & (wr_data_i[NIB_W-1:0] != in_q))
                   | (wr_out & (wr_data_i[OUT_W-1:0] != out_q));

  assign in_sel_o  = in_q;
  assign out_sel_o = out_q;

  a_r7_soft_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (in_q == '0) && (out_q == OUT_RST));

  a_r2_upper_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_in && !soft_rst_i) |=> in_q == $past(wr_data_i[NIB_W-1:0]));
endmodule

// File: rtl/sv_clkgen_counter.sv
module sv_clkgen_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end

  a_r5_clear_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);

  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));
endmodule

// File: rtl/sv_clkgen_tap.sv
module sv_clkgen_tap
  import sv_clkgen_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              clk_o
);
  logic off, tap_d;

  assign off = code_off(code_i);

  always_comb begin
    tap_d = 1'b0;
    if (!off && (int'(code_i) < int'(CNT_W))) tap_d = cnt_i[code_i];
  end

  // registered tap keeps the output glitch-free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_o <= 1'b0;
    else         clk_o <= tap_d;
  end

  a_r3_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off |=> !clk_o);
endmodule

// File: rtl/sv_clkgen_settle.sv
module sv_clkgen_settle #(
  parameter int unsigned SETTLE_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic valid_o
);
  localparam int unsigned CW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= LOAD_V;
    else if (load_i)        cnt_q <= LOAD_V;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign valid_o = (cnt_q == '0);

  a_r8_settle_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !valid_o);

  a_r8_stays_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !load_i) |=> valid_o);
endmodule

// File: rtl/sv_clkgen_top.sv
module sv_clkgen_top
  import sv_clkgen_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned SETTLE_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_rst_i,
  input  logic              sw_rst_i,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [SRC_W-1:0]  src_sel_o,
  output logic              sclk_o,
  output logic              vclk_o,
  output logic              clock_valid_o
);
  logic [NIB_W-1:0]    in_sel;
  logic [OUT_W-1:0]    out_sel;
  logic                changed, soft_rst, sync_clr;
  logic [CNT_W-1:0]    cnt;
  logic [NUM_TAPS-1:0] tap_clk;
  logic [CODE_W-1:0]   vcode, scode;

  assign soft_rst = hw_rst_i | sw_rst_i;

  sv_clkgen_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .in_sel_o   (in_sel),
    .out_sel_o  (out_sel),
    .changed_o  (changed)
  );

  assign src_sel_o = decode_src(in_sel);
  assign vcode     = out_sel[TAP_VCLK*CODE_W +: CODE_W];
  assign scode     = out_sel[TAP_SCLK*CODE_W +: CODE_W];
  // both outputs disabled is the sync pattern
  assign sync_clr  = code_off(vcode) & code_off(scode);

  sv_clkgen_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sync_clr),
    .cnt_o  (cnt)
  );

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    sv_clkgen_tap #(.CNT_W(CNT_W)) u_tap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (cnt),
      .code_i (out_sel[t*CODE_W +: CODE_W]),
      .clk_o  (tap_clk[t])
    );
  end

  assign vclk_o = tap_clk[TAP_VCLK];
  assign sclk_o = tap_clk[TAP_SCLK];

  sv_clkgen_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (changed),
    .valid_o (clock_valid_o)
  );

  a_r6_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sclk_o) && $stable(out_sel) && $past($stable(out_sel)) &&
     !code_off(vcode) && (vcode < scode)) |-> $fell(vclk_o));

  a_r7_soft_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (src_sel_o == '0) && !clock_valid_o);
endmodule

// File: tb/tb_sv_clkgen_top.sv
module tb_sv_clkgen_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 3;
  localparam int NV         = 9;
  localparam int NS         = 9;

  localparam logic [7:0] OUT_VEC [NV] = '{8'h00, 8'h08, 8'h2A, 8'h1B, 8'h06,
                                           8'h3C, 8'hC9, 8'h11, 8'h28};
  // {write data, expected source index}
  localparam logic [10:0] SRC_VEC [NS] = '{{8'h00, 3'd0}, {8'h01, 3'd1}, {8'h02, 3'd2},
                                            {8'h03, 3'd3}, {8'h04, 3'd3}, {8'h08, 3'd4},
                                            {8'hF1, 3'd1}, {8'h05, 3'd0}, {8'hA8, 3'd4}};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_rst = 1'b0, sw_rst = 1'b0;
  logic       wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] src_sel;
  logic       sclk, vclk, cvalid;

  int checks = 0, errors = 0;
  bit done = 0;
  bit chk_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sv_clkgen_top #(.CNT_W(8), .SETTLE_CYC(SETTLE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .hw_rst_i(hw_rst), .sw_rst_i(sw_rst),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .src_sel_o(src_sel), .sclk_o(sclk), .vclk_o(vclk), .clock_valid_o(cvalid)
  );

  // reference model from the requirements
  logic [3:0] m_in;
  logic [5:0] m_out;
  logic [7:0] m_cnt;
  logic       m_sclk, m_vclk;
  int         m_settle;

  function automatic logic [2:0] ref_src(input logic [3:0] c);
    if (c == 4'd3 || c == 4'd4) return 3'd3;
    if (c == 4'd8) return 3'd4;
    if (c <= 4'd2) return c[2:0];
    return 3'd0;
  endfunction

  function automatic logic ref_tap(input logic [2:0] code, input logic [7:0] c);
    if (code >= 3'd6) return 1'b0;
    return c[code];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_in <= '0; m_out <= 6'h36; m_cnt <= '0; m_sclk <= 0; m_vclk <= 0; m_settle <= SETTLE;
    end else begin
      m_sclk <= ref_tap(m_out[5:3], m_cnt);
      m_vclk <= ref_tap(m_out[2:0], m_cnt);
      m_cnt  <= (m_out[5:4] == 2'b11 && m_out[2:1] == 2'b11) ? 8'd0 : m_cnt + 8'd1;
      if (hw_rst || sw_rst) begin
        m_in <= '0; m_out <= 6'h36; m_settle <= SETTLE;
      end else if (wr_en && !wr_addr && wr_data[3:0] != m_in) begin
        m_in <= wr_data[3:0]; m_settle <= SETTLE;
      end else if (wr_en && wr_addr && wr_data[5:0] != m_out) begin
        m_out <= wr_data[5:0]; m_settle <= SETTLE;
      end else if (m_settle > 0) m_settle <= m_settle - 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    check(sclk == m_sclk, "R3 R6 sclk", sclk, m_sclk);
    check(vclk == m_vclk, "R3 R6 vclk", vclk, m_vclk);
    check(src_sel == ref_src(m_in), "R2 src", src_sel, ref_src(m_in));
    check(cvalid == (m_settle == 0), "R8 valid", cvalid, m_settle == 0);
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int k, hi, lo;
    // R1 reset state
    repeat (2) @(negedge clk);
    check(src_sel == 0 && !sclk && !vclk && !cvalid, "R1 in reset", {src_sel, sclk, vclk, cvalid}, 0);
    rst_n = 1;
    @(negedge clk);
    check(src_sel == 0 && !sclk && !vclk && !cvalid, "R1 after release", {src_sel, sclk, vclk, cvalid}, 0);
    chk_on = 1;
    repeat (SETTLE + 2) @(negedge clk);

    // R2 source select table
    for (int i = 0; i < NS; i++) begin
      wr(1'b0, SRC_VEC[i][10:3]);
      check(src_sel == SRC_VEC[i][2:0], "R2 decode", src_sel, SRC_VEC[i][2:0]);
      repeat (SETTLE + 1) @(negedge clk);
    end

    // R3 R6 output code table, checked per cycle by the model
    for (int i = 0; i < NV; i++) begin
      wr(1'b1, OUT_VEC[i]);
      repeat (140) @(negedge clk);
    end

    // R5 clear and release phase
    wr(1'b1, 8'h36);
    repeat (20) @(negedge clk);
    check(!sclk && !vclk, "R5 held low", {sclk, vclk}, 0);
    wr(1'b1, 8'h08);
    k = 0;
    while (!vclk && k < 20) begin @(negedge clk); k++; end
    check(k == 2, "R5 first vclk rise", k, 2);
    while (!sclk && k < 20) begin @(negedge clk); k++; end
    check(k == 3, "R5 first sclk rise", k, 3);

    // R4 period with code 2
    wr(1'b1, 8'h10);
    repeat (20) @(negedge clk);
    while (sclk) @(negedge clk);
    while (!sclk) @(negedge clk);
    hi = 0; while (sclk) begin hi++; @(negedge clk); end
    lo = 0; while (!sclk) begin lo++; @(negedge clk); end
    check(hi == 4, "R4 high time", hi, 4);
    check(lo == 4, "R4 low time", lo, 4);

    // R8 settle timing and same-value write
    repeat (SETTLE + 2) @(negedge clk);
    wr(1'b1, 8'h10);
    check(cvalid, "R8 same value keeps valid", cvalid, 1);
    wr(1'b0, 8'h02);
    check(!cvalid, "R8 drop", cvalid, 0);
    repeat (SETTLE - 1) @(negedge clk);
    check(!cvalid, "R8 still settling", cvalid, 0);
    @(negedge clk);
    check(cvalid, "R8 valid again", cvalid, 1);

    // R7 hardware and software resets
    wr(1'b1, 8'h00);
    repeat (10) @(negedge clk);
    hw_rst = 1; @(negedge clk); hw_rst = 0;
    check(src_sel == 0 && !cvalid, "R7 hw defaults", {src_sel, cvalid}, 0);
    repeat (3) @(negedge clk);
    check(!sclk && !vclk, "R7 hw outputs low", {sclk, vclk}, 0);
    wr(1'b0, 8'h01);
    wr(1'b1, 8'h09);
    repeat (10) @(negedge clk);
    sw_rst = 1; @(negedge clk); sw_rst = 0;
    check(src_sel == 0 && !cvalid, "R7 sw defaults", {src_sel, cvalid}, 0);
    repeat (3) @(negedge clk);
    check(!sclk && !vclk, "R7 sw outputs low", {sclk, vclk}, 0);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule